// File: doc/BRIEF.md
# Priority-Preemptive Virtual-Channel Output Arbiter

This block decides, cycle by cycle, which flit crosses one router output link that carries several virtual channels. Each channel has its own arbiter choosing among the input ports that present a flit for this output on that channel. Channel index 0 has the highest priority, and higher indices have lower priority. Each arbiter is built in one of three modes chosen per channel at elaboration: no arbitration (a lone requester is passed through), fixed priority (lowest input index wins), or round robin.

The arbiters form a freeze chain. A channel that has a flit ready holds back every channel of lower priority. A lower-priority packet that is part-way across the link is therefore suspended flit by flit. It keeps its owner and its arbiter state, and it carries on from the same input once the higher channels have nothing ready. A grant taken on a header flit stays with that input until its tail flit crosses (wormhole lock). The block drives one grant per input and channel, together with the channel and input selects of the output multiplexer. Grants are combinational in the same cycle as the request.

Top module: `vc_out_arb`

## Requirements
- R1: While reset is held and after its release with no requests, no grant is asserted and `link_valid_o` is low. All channels start unlocked and every round-robin pointer starts at input 0.
- R2: At most one bit of `gnt_o` is set in any cycle. `link_valid_o` is high exactly when a grant is set, and `link_vc_o`/`link_sel_o` then give that grant's channel and input.
- R3: When several channels have a flit ready, the channel with the lowest index is granted. All channels of higher index are frozen in that cycle.
- R4: A channel frozen part-way through a packet resumes with the same input, even if other inputs now request on it.
- R5: After a non-tail flit is granted on a channel, only that input is granted on that channel until a flit with `tail_i` set crosses. Requests from other inputs on that channel are not granted meanwhile.
- R6: In fixed-priority mode (channel 1 by default), an unlocked channel grants the lowest-indexed requesting input.
- R7: In round-robin mode (channel 2 by default), an unlocked channel grants the first requesting input at or above its pointer, wrapping from the top input to input 0. The pointer moves to the input after the winner only when that winner's tail flit is granted.
- R8: In no-arbitration mode (channel 0 by default), an unlocked channel grants its single requester. More than one request on it while unlocked is an error.
- R9: A frozen channel keeps its lock, owner and round-robin pointer unchanged.
- R10: A locked channel whose owning input has no flit present does not freeze lower channels, so a lower channel may use the link in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_VC x NUM_IN | `req_i[v][i]`: input i has a flit for this output on channel v |
| tail_i | input | NUM_VC x NUM_IN | `tail_i[v][i]`: that flit is the last of its packet |
| gnt_o | output | NUM_VC x NUM_IN | `gnt_o[v][i]`: the flit of input i on channel v crosses this cycle |
| link_valid_o | output | 1 | A flit crosses the link this cycle |
| link_vc_o | output | VW | Channel index driving the link |
| link_sel_o | output | IW | Input index driving the link |

## Verification
Two functions meet in the same cycle: a higher channel freezing a lower one, and the lower channel's own wormhole lock or round-robin pointer update, which must then be held back. The bench provokes this by opening a packet on the round-robin channel and then raising higher-channel flits while other inputs on the frozen channel also request. When the higher channels fall silent, it checks that the suspended packet resumes on its original input and that the next round-robin choice follows the pointer left by the last tail, not by a frozen cycle. A separate case places a bubble in a locked high channel, and the bench checks that a lower channel gets the link in that cycle.

// File: rtl/vc_arb_pkg.sv
package vc_arb_pkg;
    typedef enum logic [1:0] {
        ARB_NONE  = 2'd0,
        ARB_FIXED = 2'd1,
        ARB_RR    = 2'd2
    } arb_mode_e;
endpackage

// File: rtl/vc_pick.sv
module vc_pick
    import vc_arb_pkg::*;
#(
    parameter int        NUM_IN = 4,
    parameter arb_mode_e MODE   = ARB_FIXED,
    localparam int       IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] req_i,
    input  logic [IW-1:0]     ptr_i,
    output logic [IW-1:0]     pick_o,
    output logic              any_o
);
    assign any_o = |req_i;

    generate
        if (MODE == ARB_RR) begin : g_rr
            always_comb begin
                logic found;
                found  = 1'b0;
                pick_o = '0;
                for (int k = 0; k < NUM_IN; k++) begin
                    int idx;
                    idx = (int'(ptr_i) + k) % NUM_IN;
                    if (!found && req_i[idx]) begin
                        found  = 1'b1;
                        pick_o = IW'(idx);
                    end
                end
            end
        end else if (MODE == ARB_FIXED) begin : g_fixed
            logic unused_ptr;
            assign unused_ptr = ^ptr_i;
            always_comb begin
                pick_o = '0;
                for (int i = NUM_IN - 1; i >= 0; i--) begin
                    if (req_i[i]) pick_o = IW'(i);
                end
            end
        end else begin : g_none
            // single requester assumed: OR-encode its index, no priority chain
            logic unused_ptr;
            assign unused_ptr = ^ptr_i;
            always_comb begin
                pick_o = '0;
                for (int i = 0; i < NUM_IN; i++) begin
                    if (req_i[i]) pick_o = pick_o | IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vc_lane.sv
module vc_lane
    import vc_arb_pkg::*;
#(
    parameter int        NUM_IN = 4,
    parameter arb_mode_e MODE   = ARB_FIXED,
    localparam int       IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] req_i,
    input  logic [NUM_IN-1:0] tail_i,
    input  logic              frozen_i,
    output logic              rdy_o,
    output logic [IW-1:0]     cand_o,
    output logic [NUM_IN-1:0] gnt_o
);
    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } lane_st_t;

    lane_st_t      st_d, st_q;
    logic [IW-1:0] pick;
    logic          any_req;

    vc_pick #(.NUM_IN(NUM_IN), .MODE(MODE)) u_pick (
        .req_i  (req_i),
        .ptr_i  (st_q.ptr),
        .pick_o (pick),
        .any_o  (any_req)
    );

    always_comb begin
        logic send;
        st_d   = st_q;
        cand_o = st_q.locked ? st_q.owner : pick;
        rdy_o  = st_q.locked ? req_i[st_q.owner] : any_req;
        send   = rdy_o && !frozen_i;
        gnt_o  = '0;
        if (send) begin
            gnt_o[cand_o] = 1'b1;
            if (tail_i[cand_o]) begin
                st_d.locked = 1'b0;
                if (MODE == ARB_RR)
                    st_d.ptr = (int'(cand_o) == NUM_IN - 1) ? '0 : cand_o + 1'b1;
            end else begin
                st_d.locked = 1'b1;
                st_d.owner  = cand_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_i |=> $stable(st_q));

    assert_lock_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && (|gnt_o)) |-> gnt_o[st_q.owner]);

    generate
        if (MODE == ARB_NONE) begin : g_chk_none
            assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.locked |-> $onehot0(req_i));
        end
    endgenerate
endmodule

// File: rtl/vc_out_arb.sv
module vc_out_arb
    import vc_arb_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_VC   = 3,
    parameter logic [2*NUM_VC-1:0] VC_MODES = {ARB_RR, ARB_FIXED, ARB_NONE},
    localparam int         IW       = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int         VW       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_VC-1:0][NUM_IN-1:0] req_i,
    input  logic [NUM_VC-1:0][NUM_IN-1:0] tail_i,
    output logic [NUM_VC-1:0][NUM_IN-1:0] gnt_o,
    output logic                          link_valid_o,
    output logic [VW-1:0]                 link_vc_o,
    output logic [IW-1:0]                 link_sel_o
);
    logic [NUM_VC-1:0]         rdy;
    logic [NUM_VC-1:0]         frz;
    logic [NUM_VC-1:0][IW-1:0] cand;

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            if (v == 0) begin : g_head
                assign frz[v] = 1'b0;
            end else begin : g_link
                assign frz[v] = frz[v-1] | rdy[v-1];
            end

            vc_lane #(
                .NUM_IN (NUM_IN),
                .MODE   (arb_mode_e'(VC_MODES[2*v +: 2]))
            ) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .req_i    (req_i[v]),
                .tail_i   (tail_i[v]),
                .frozen_i (frz[v]),
                .rdy_o    (rdy[v]),
                .cand_o   (cand[v]),
                .gnt_o    (gnt_o[v])
            );

            if (v > 0) begin : g_chk_prio
                assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (|gnt_o[v]) |-> !(|rdy[v-1:0]));
            end
        end
    endgenerate

    always_comb begin
        link_valid_o = 1'b0;
        link_vc_o    = '0;
        link_sel_o   = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (|gnt_o[v]) begin
                link_valid_o = 1'b1;
                link_vc_o    = VW'(v);
                link_sel_o   = cand[v];
            end
        end
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) <= 1);

    assert_link_names_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid_o |-> gnt_o[link_vc_o][link_sel_o]);
endmodule

// File: tb/tb_vc_out_arb.sv
module tb_vc_out_arb;
    localparam int NI = 4;
    localparam int NV = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NV-1:0][NI-1:0] req = '0;
    logic [NV-1:0][NI-1:0] tail = '0;
    logic [NV-1:0][NI-1:0] gnt;
    logic                  link_valid;
    logic [1:0]            link_vc;
    logic [1:0]            link_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit    valid;
        int    vc;
        int    in;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    vc_out_arb dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tail_i(tail),
        .gnt_o(gnt), .link_valid_o(link_valid),
        .link_vc_o(link_vc), .link_sel_o(link_sel)
    );

    task automatic step(input logic [NV-1:0][NI-1:0] r, input logic [NV-1:0][NI-1:0] t,
                        input bit ev, input int evc, input int ein, input string tag);
        exp_t e;
        @(negedge clk);
        req  = r;
        tail = t;
        e.valid = ev; e.vc = evc; e.in = ein; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                logic [NV-1:0][NI-1:0] eg;
                e  = q.pop_front();
                eg = '0;
                if (e.valid) eg[e.vc][e.in] = 1'b1;
                n_tests++;
                if (link_valid !== e.valid) begin
                    n_fail++;
                    $display("FAIL %s link_valid actual=%0b expected=%0b", e.tag, link_valid, e.valid);
                end
                n_tests++;
                if (gnt !== eg) begin
                    n_fail++;
                    $display("FAIL %s gnt actual=%h expected=%h", e.tag, gnt, eg);
                end
                if (e.valid) begin
                    n_tests++;
                    if (int'(link_vc) != e.vc || int'(link_sel) != e.in) begin
                        n_fail++;
                        $display("FAIL %s vc/sel actual=%0d/%0d expected=%0d/%0d",
                                 e.tag, link_vc, link_sel, e.vc, e.in);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        #5;
        n_tests++;
        if (link_valid !== 1'b0 || gnt !== '0) begin
            n_fail++;
            $display("FAIL R1 in reset actual=%0b/%h expected=0/0", link_valid, gnt);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step('0, '0, 0, 0, 0, "R1 idle after reset");
        // channel 1, fixed priority
        step({4'b0000, 4'b1010, 4'b0000}, '0, 1, 1, 1, "R6 lowest requester");
        step({4'b0000, 4'b1011, 4'b0000}, '0, 1, 1, 1, "R5 lock holds owner");
        step({4'b0000, 4'b1011, 4'b0000}, {4'b0000, 4'b0010, 4'b0000}, 1, 1, 1, "R5 tail of owner");
        step({4'b0000, 4'b1001, 4'b0000}, {4'b0000, 4'b1001, 4'b0000}, 1, 1, 0, "R6 after unlock");
        // channel 2, round robin, with preemption
        step({4'b0100, 4'b0000, 4'b0000}, '0, 1, 2, 2, "R7 first at/above ptr 0");
        step({4'b0100, 4'b0000, 4'b0010}, '0, 1, 0, 1, "R3 R4 preempt mid-packet");
        step({4'b0101, 4'b0000, 4'b0010}, {4'b0000, 4'b0000, 4'b0010}, 1, 0, 1, "R4 still frozen");
        step({4'b0101, 4'b0000, 4'b0000}, {4'b0100, 4'b0000, 4'b0000}, 1, 2, 2, "R4 resume same owner");
        step({4'b0101, 4'b0000, 4'b0000}, {4'b0101, 4'b0000, 4'b0000}, 1, 2, 0, "R7 wrap from ptr 3");
        step({4'b0100, 4'b0000, 4'b0000}, {4'b0100, 4'b0000, 4'b0000}, 1, 2, 2, "R7 ptr 1");
        // frozen round-robin pointer must stay at 3
        step({4'b1010, 4'b0001, 4'b0000}, {4'b1010, 4'b0000, 4'b0000}, 1, 1, 0, "R3 ch1 over ch2");
        step({4'b1010, 4'b0001, 4'b0000}, {4'b1010, 4'b0001, 4'b0000}, 1, 1, 0, "R9 ch2 frozen");
        step({4'b1010, 4'b0000, 4'b0000}, {4'b1010, 4'b0000, 4'b0000}, 1, 2, 3, "R9 ptr kept at 3");
        // bubble in locked channel 0, no-arbitration mode
        step({4'b0000, 4'b0000, 4'b0100}, '0, 1, 0, 2, "R8 single requester");
        step({4'b0000, 4'b1000, 4'b0000}, {4'b0000, 4'b1000, 4'b0000}, 1, 1, 3, "R10 bubble lets ch1 pass");
        step({4'b0000, 4'b0000, 4'b0101}, {4'b0000, 4'b0000, 4'b0100}, 1, 0, 2, "R5 other input ignored");
        step({4'b0000, 4'b0000, 4'b0001}, {4'b0000, 4'b0000, 4'b0001}, 1, 0, 0, "R8 new single requester");
        // all three channels ready
        step({4'b0010, 4'b0010, 4'b1000}, {4'b0010, 4'b0010, 4'b1000}, 1, 0, 3, "R3 ch0 wins");
        step({4'b0010, 4'b0010, 4'b0000}, {4'b0010, 4'b0010, 4'b0000}, 1, 1, 1, "R3 ch1 next");
        step({4'b0010, 4'b0000, 4'b0000}, {4'b0010, 4'b0000, 4'b0000}, 1, 2, 1, "R7 ptr 0 to in1");
        step('0, '0, 0, 0, 0, "R2 idle no grant");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule